// File: doc/BRIEF.md
# Counted Loop Branch Unit

This unit carries out one count-controlled conditional branch of a 16-bit processor. Each operation is launched by a single-cycle start strobe. The unit takes the address of the branch instruction, its length in bytes, a signed 8-bit displacement, the count register, the zero flag and a variant select. It lowers the count by one and tests the result, alone or together with the zero flag. It then reports the new count, whether the branch is taken, the address of the next instruction and the number of clock cycles charged for the operation.

The zero flag is passed back out as it was sampled at start, so the operation leaves the flags unchanged. Instruction decode, fetch and the register file sit around the unit and are not part of it.

A two-state controller drives the result. The states are ST_IDLE and ST_REPORT. The transition ST_IDLE to ST_REPORT happens on start, and ST_REPORT to ST_REPORT happens on a back-to-back start. ST_REPORT returns to ST_IDLE when no start is present. The done output is high exactly while the controller is in ST_REPORT. Every result register loads on the same edge that accepts start.

Top module: `counted_loop_unit`

## Requirements
- R1: The count output equals the count input minus one, modulo 2^16, for every variant. A count input of 0x0000 yields 0xFFFF.
- R2: With variant code 2'b00 (plain loop), the branch is taken if and only if the decremented count is nonzero.
- R3: With variant code 2'b01 (loop while equal), the branch is taken if and only if the decremented count is nonzero and the zero flag is 1.
- R4: With variant code 2'b10 (loop while not equal), the branch is taken if and only if the decremented count is nonzero and the zero flag is 0.
- R5: Variant code 2'b11 is reserved. It never takes the branch, but it still decrements the count.
- R6: The next address is computed modulo 2^16. When the branch is not taken it is the instruction address plus the length. When the branch is taken it is that sum plus the displacement sign-extended to 16 bits.
- R7: The cycle count output is 17 when the branch is taken and 5 when it is not.
- R8: The zero flag output equals the zero flag input sampled with start, so the operation never alters it.
- R9: done goes high for exactly the one cycle after each start strobe. All result outputs hold their values until the next start.
- R10: After reset, done, taken, the count output, the next address, the cycle count and the zero flag output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one operation |
| ip_in | input | 16 | Address of the branch instruction |
| ins_len | input | 4 | Branch instruction length in bytes |
| disp | input | 8 | Signed relative displacement |
| count_in | input | 16 | Count register before the operation |
| zf_in | input | 1 | Zero flag before the operation |
| variant | input | 2 | 00 plain, 01 while equal, 10 while not equal, 11 reserved |
| done | output | 1 | One-cycle result pulse |
| count_out | output | 16 | Decremented count |
| taken | output | 1 | Branch taken |
| next_ip | output | 16 | Address of the next instruction |
| cycles | output | 5 | Clock cycles charged |
| zf_out | output | 1 | Zero flag after the operation |

## Verification
A controller stuck in ST_REPORT or in ST_IDLE shows up at the done port one cycle after a start strobe. A stuck ST_REPORT gives a done that stays high. A stuck ST_IDLE gives a done that never rises. A wrong predicate or a wrong decrement appears in taken, count_out and cycles in that same cycle. The same result is checked again after idle cycles, so results that drift while the unit is idle are caught. Count values of 0 and 1 and displacements of -128 and +127 exercise the wrap and sign-extension edges.

// File: rtl/clu_pkg.sv
package clu_pkg;
    typedef enum logic [1:0] {
        LK_PLAIN    = 2'b00,
        LK_WHILE_EQ = 2'b01,
        LK_WHILE_NE = 2'b10,
        LK_RSVD     = 2'b11
    } loop_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/clu_decide.sv
module clu_decide
    import clu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             zf,
    input  loop_kind_e       kind,
    output logic [CNT_W-1:0] cnt_dec,
    output logic             go
);
    logic nz;

    always_comb begin
        cnt_dec = cnt - CNT_W'(1);
        nz      = |cnt_dec;
        unique case (kind)
            LK_PLAIN:    go = nz;
            LK_WHILE_EQ: go = nz & zf;
            LK_WHILE_NE: go = nz & ~zf;
            default:     go = 1'b0;
        endcase
    end
endmodule

// File: rtl/clu_target.sv
module clu_target #(
    parameter int IP_W   = 16,
    parameter int LEN_W  = 4,
    parameter int DISP_W = 8
) (
    input  logic [IP_W-1:0]   ip,
    input  logic [LEN_W-1:0]  len,
    input  logic [DISP_W-1:0] disp,
    output logic [IP_W-1:0]   seq_ip,
    output logic [IP_W-1:0]   jmp_ip
);
    localparam int PAD_LEN  = IP_W - LEN_W;
    localparam int PAD_DISP = IP_W - DISP_W;

    always_comb begin
        seq_ip = ip + {{PAD_LEN{1'b0}}, len};
        jmp_ip = seq_ip + {{PAD_DISP{disp[DISP_W-1]}}, disp};
    end
endmodule

// File: rtl/clu_ctrl.sv
module clu_ctrl
    import clu_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int IP_W      = 16,
    parameter int CYC_W     = 5,
    parameter int TAKEN_CYC = 17,
    parameter int FALL_CYC  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_dec,
    input  logic             go,
    input  logic [IP_W-1:0]  seq_ip,
    input  logic [IP_W-1:0]  jmp_ip,
    input  logic             zf,
    output logic             done,
    output logic [CNT_W-1:0] count_q,
    output logic             taken_q,
    output logic [IP_W-1:0]  ip_q,
    output logic [CYC_W-1:0] cyc_q,
    output logic             zf_q
);
    ctrl_state_e state, state_nx;

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = start ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nx = start ? ST_REPORT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            taken_q <= 1'b0;
            ip_q    <= '0;
            cyc_q   <= '0;
            zf_q    <= 1'b0;
        end else if (start) begin
            count_q <= cnt_dec;
            taken_q <= go;
            ip_q    <= go ? jmp_ip : seq_ip;
            cyc_q   <= go ? CYC_W'(TAKEN_CYC) : CYC_W'(FALL_CYC);
            zf_q    <= zf;
        end
    end

    assign done = (state == ST_REPORT);

    p_done_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    p_done_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(count_q) && $stable(ip_q) && $stable(taken_q)));
    p_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_q == (taken_q ? CYC_W'(TAKEN_CYC) : CYC_W'(FALL_CYC))));
endmodule

// File: rtl/counted_loop_unit.sv
module counted_loop_unit
    import clu_pkg::*;
#(
    parameter int IP_W      = 16,
    parameter int CNT_W     = 16,
    parameter int LEN_W     = 4,
    parameter int DISP_W    = 8,
    parameter int TAKEN_CYC = 17,
    parameter int FALL_CYC  = 5,
    localparam int CYC_W    = $clog2(TAKEN_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IP_W-1:0]   ip_in,
    input  logic [LEN_W-1:0]  ins_len,
    input  logic [DISP_W-1:0] disp,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              zf_in,
    input  logic [1:0]        variant,
    output logic              done,
    output logic [CNT_W-1:0]  count_out,
    output logic              taken,
    output logic [IP_W-1:0]   next_ip,
    output logic [CYC_W-1:0]  cycles,
    output logic              zf_out
);
    logic [CNT_W-1:0] cnt_dec;
    logic             go;
    logic [IP_W-1:0]  seq_ip, jmp_ip;

    clu_decide #(.CNT_W(CNT_W)) u_decide (
        .cnt     (count_in),
        .zf      (zf_in),
        .kind    (loop_kind_e'(variant)),
        .cnt_dec (cnt_dec),
        .go      (go)
    );

    clu_target #(.IP_W(IP_W), .LEN_W(LEN_W), .DISP_W(DISP_W)) u_target (
        .ip     (ip_in),
        .len    (ins_len),
        .disp   (disp),
        .seq_ip (seq_ip),
        .jmp_ip (jmp_ip)
    );

    clu_ctrl #(
        .CNT_W(CNT_W), .IP_W(IP_W), .CYC_W(CYC_W),
        .TAKEN_CYC(TAKEN_CYC), .FALL_CYC(FALL_CYC)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cnt_dec (cnt_dec),
        .go      (go),
        .seq_ip  (seq_ip),
        .jmp_ip  (jmp_ip),
        .zf      (zf_in),
        .done    (done),
        .count_q (count_out),
        .taken_q (taken),
        .ip_q    (next_ip),
        .cyc_q   (cycles),
        .zf_q    (zf_out)
    );

    p_count_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_out == $past(count_in) - CNT_W'(1)));
    p_flag_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (zf_out == $past(zf_in)));
    p_rsvd_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && variant == 2'b11) |=> !taken);
    p_zero_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && count_in == CNT_W'(1)) |=> !taken);
    p_fall_ip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (next_ip == $past(ip_in) + IP_W'($past(ins_len))));
endmodule

// File: tb/counted_loop_unit_bench.sv
`timescale 1ns/1ps
module counted_loop_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ip_in = '0;
    logic [3:0]  ins_len = '0;
    logic [7:0]  disp = '0;
    logic [15:0] count_in = '0;
    logic        zf_in = 1'b0;
    logic [1:0]  variant = '0;
    logic        done;
    logic [15:0] count_out;
    logic        taken;
    logic [15:0] next_ip;
    logic [4:0]  cycles;
    logic        zf_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    counted_loop_unit u_counted_loop_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .ip_in(ip_in), .ins_len(ins_len),
        .disp(disp), .count_in(count_in), .zf_in(zf_in), .variant(variant),
        .done(done), .count_out(count_out), .taken(taken), .next_ip(next_ip),
        .cycles(cycles), .zf_out(zf_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one operation, check every output in the cycle after start.
    task automatic run_op(input logic [15:0] ip, input logic [3:0] len, input logic [7:0] d,
                          input logic [15:0] cnt, input logic zf, input logic [1:0] v,
                          input string req);
        logic [15:0] e_cnt, e_seq, e_ip;
        logic        e_tk;
        e_cnt = cnt - 16'd1;
        case (v)
            2'b00:   e_tk = (e_cnt != 0);
            2'b01:   e_tk = (e_cnt != 0) && zf;
            2'b10:   e_tk = (e_cnt != 0) && !zf;
            default: e_tk = 1'b0;
        endcase
        e_seq = ip + {12'd0, len};
        e_ip  = e_tk ? e_seq + {{8{d[7]}}, d} : e_seq;
        @(negedge clk);
        ip_in = ip; ins_len = len; disp = d; count_in = cnt; zf_in = zf; variant = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " done R9"}, {31'd0, done}, 32'd1);
        chk({req, " count R1"}, {16'd0, count_out}, {16'd0, e_cnt});
        chk({req, " taken"}, {31'd0, taken}, {31'd0, e_tk});
        chk({req, " next_ip R6"}, {16'd0, next_ip}, {16'd0, e_ip});
        chk({req, " cycles R7"}, {27'd0, cycles}, e_tk ? 32'd17 : 32'd5);
        chk({req, " zf R8"}, {31'd0, zf_out}, {31'd0, zf});
        @(negedge clk);
        chk({req, " done pulse R9"}, {31'd0, done}, 32'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R10 done", {31'd0, done}, 0);
        chk("R10 taken", {31'd0, taken}, 0);
        chk("R10 count", {16'd0, count_out}, 0);
        chk("R10 next_ip", {16'd0, next_ip}, 0);
        chk("R10 cycles", {27'd0, cycles}, 0);
        chk("R10 zf", {31'd0, zf_out}, 0);
    endtask

    task automatic test_plain();
        run_op(16'h1000, 4'd2, 8'hF0, 16'd5, 1'b0, 2'b00, "R2 mid");
        run_op(16'h1000, 4'd2, 8'hF0, 16'd1, 1'b1, 2'b00, "R2 last");
        run_op(16'h2000, 4'd2, 8'h10, 16'd0, 1'b0, 2'b00, "R2 R1 wrap");
        run_op(16'h2000, 4'd2, 8'h10, 16'd2, 1'b1, 2'b00, "R2 two");
    endtask

    task automatic test_equal();
        run_op(16'h3000, 4'd2, 8'hFA, 16'd9, 1'b1, 2'b01, "R3 zf1");
        run_op(16'h3000, 4'd2, 8'hFA, 16'd9, 1'b0, 2'b01, "R3 zf0");
        run_op(16'h3000, 4'd2, 8'hFA, 16'd1, 1'b1, 2'b01, "R3 cnt1");
    endtask

    task automatic test_not_equal();
        run_op(16'h4000, 4'd2, 8'h05, 16'd9, 1'b0, 2'b10, "R4 zf0");
        run_op(16'h4000, 4'd2, 8'h05, 16'd9, 1'b1, 2'b10, "R4 zf1");
        run_op(16'h4000, 4'd2, 8'h05, 16'd1, 1'b0, 2'b10, "R4 cnt1");
    endtask

    task automatic test_reserved();
        run_op(16'h5000, 4'd3, 8'h20, 16'd7, 1'b1, 2'b11, "R5 zf1");
        run_op(16'h5000, 4'd3, 8'h20, 16'd7, 1'b0, 2'b11, "R5 zf0");
    endtask

    task automatic test_targets();
        run_op(16'h0100, 4'd2, 8'h80, 16'd3, 1'b0, 2'b00, "R6 minus128");
        run_op(16'h0100, 4'd2, 8'h7F, 16'd3, 1'b0, 2'b00, "R6 plus127");
        run_op(16'hFFFE, 4'd4, 8'h01, 16'd3, 1'b0, 2'b00, "R6 wrap up");
        run_op(16'h0002, 4'd1, 8'hF8, 16'd3, 1'b1, 2'b00, "R6 wrap down");
        run_op(16'hFFFF, 4'd15, 8'h00, 16'd1, 1'b0, 2'b00, "R6 fall wrap");
    endtask

    task automatic test_hold();
        run_op(16'h6000, 4'd2, 8'hFE, 16'd4, 1'b1, 2'b01, "R9 hold");
        @(negedge clk);
        ip_in = 16'h1234; count_in = 16'h0042; disp = 8'h33; zf_in = 1'b0; variant = 2'b10;
        repeat (3) @(negedge clk);
        chk("R9 hold count", {16'd0, count_out}, 32'h0003);
        chk("R9 hold ip", {16'd0, next_ip}, 32'h6002 + 32'hFFFE - 32'h10000);
        chk("R9 hold taken", {31'd0, taken}, 1);
        chk("R9 hold zf", {31'd0, zf_out}, 1);
        chk("R9 hold done", {31'd0, done}, 0);
        // back-to-back strobes
        @(negedge clk);
        count_in = 16'd8; variant = 2'b00; ip_in = 16'h0010; ins_len = 4'd2; disp = 8'h04; start = 1'b1;
        @(negedge clk);
        chk("R9 b2b first done", {31'd0, done}, 1);
        chk("R1 b2b first count", {16'd0, count_out}, 7);
        count_in = 16'd1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 b2b second done", {31'd0, done}, 1);
        chk("R2 b2b second taken", {31'd0, taken}, 0);
        chk("R6 b2b second ip", {16'd0, next_ip}, 32'h0012);
        @(negedge clk);
        chk("R9 b2b end", {31'd0, done}, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_plain();
        test_equal();
        test_not_equal();
        test_reserved();
        test_targets();
        test_hold();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule